// File: doc/BRIEF.md
# Clock Source Mode Controller

This block selects and conditions the system clock. It has two sources: an internal reference clock and the output of a frequency-locked loop. A mode register, written from the register clock domain, chooses one of four operating modes. Each mode sets three things on its own terms: whether the loop is powered, which source feeds the output, and whether any clock reaches the output at all. The loop is not part of this block. It appears here only as a fast clock input with a lock flag. The block also holds a 9-bit trim word for the reference oscillator and drives it out unchanged.

The selected source passes through a glitch-free two-way gate. The gate closes the old source on one of its falling edges. It opens the new source only after that source has produced a set number of synchronised rising edges. When the new source is the loop, the gate also waits for the lock flag. A power-of-two pulse divider follows the gate. It passes one full high phase of the source out of every N source cycles. A new divider setting is taken only when the divider completes a period. The loop and reference enables are dropped only after the matching gate is seen closed, so a source is never switched off while it still drives the output.

Top module: `clksrc_mode_ctrl`

## Requirements
- R1: After reset the controller is in loop-engaged mode. The divider is set to 1, the keep-reference bit is 0 and the trim output is 9'h100. Both `loop_en` and `ref_en` are high.
- R2: Mode code 0 (loop engaged): `loop_en` is high. Once `loop_lock` is high, the output edges come from `loop_clk`.
- R3: Mode code 1 (loop bypassed): `loop_en` stays high and the output edges come from `ref_clk`.
- R4: Mode code 2 (bypassed, low power): once the loop gate has closed, `loop_en` is low. The output edges come from `ref_clk`.
- R5: Mode code 3 (stop): no output edges are produced. Once both gates have closed, `loop_en` is low and `ref_en` follows the keep-reference bit.
- R6: Divider select codes 0, 1, 2 and 3 give one output pulse per 1, 2, 4 and 8 cycles of the selected source, for either source.
- R7: The two source gates are never open together. Every output high phase is one full high phase of the selected source.
- R8: A newly selected source is passed only after SYNC_N of its rising edges. The loop source is not passed while `loop_lock` is low, so the output stays quiet after leaving stop until lock is reported.
- R9: A divider change takes effect only at the end of a divided period, so no output pulse or period is shorter than one source pulse or source period.
- R10: A write with `cfg_we` high loads the trim field, and the trim appears on `ref_trim` one cycle later. Fields presented while `cfg_we` is low change neither the trim nor the mode nor the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Active-high reset, synchronous to clk (also clears the source-domain flops) |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_mode | input | 2 | Mode code: 0 loop engaged, 1 loop bypassed, 2 bypassed low power, 3 stop |
| cfg_div | input | 2 | Divider select: divide by 2^cfg_div |
| cfg_keep_ref | input | 1 | In stop mode, keep the reference enabled |
| cfg_trim | input | 9 | Trim word for the reference oscillator |
| ref_clk | input | 1 | Internal reference clock |
| loop_clk | input | 1 | Loop output clock |
| loop_lock | input | 1 | Loop lock flag, asynchronous |
| loop_en | output | 1 | Enable to the loop |
| ref_en | output | 1 | Enable to the reference oscillator |
| ref_trim | output | 9 | Held trim word |
| clk_out | output | 1 | Gated, divided system clock |

## Verification
The exclusivity property assumes that successive mode writes are spaced further apart than one complete handover. A handover is a few source cycles for the closing gate plus the synchronising edges of the opening one. The stimulus waits at least a microsecond after every write, which is far longer than a handover on the slow reference. The lock flag is treated as asynchronous, and the bench changes it only while the loop gate is held shut or the loop is not selected. Both source clocks run freely throughout, so the checks on the enables depend only on the gate status that is fed back to the register clock domain.

// File: rtl/csm_pkg.sv
package csm_pkg;
  typedef enum logic [1:0] {
    M_ENG   = 2'd0,
    M_BYP   = 2'd1,
    M_LPBYP = 2'd2,
    M_STOP  = 2'd3
  } csm_mode_e;
endpackage

// File: rtl/csm_cfg.sv
module csm_cfg
  import csm_pkg::*;
#(
  parameter int TRIM_W = 9,
  parameter int DIV_W = 2,
  parameter logic [TRIM_W-1:0] TRIM_RST = 9'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_mode,
  input  logic [DIV_W-1:0]  wr_div,
  input  logic              wr_keep,
  input  logic [TRIM_W-1:0] wr_trim,
  input  logic              ref_seen,
  input  logic              fll_seen,
  output csm_mode_e         mode_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              keep_q,
  output logic [TRIM_W-1:0] trim_q,
  output logic              want_ref,
  output logic              want_fll,
  output logic              fll_en,
  output logic              ref_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_ENG;
      div_q    <= '0;
      keep_q   <= 1'b0;
      trim_q   <= TRIM_RST;
      want_ref <= 1'b0;
      want_fll <= 1'b0;
      fll_en   <= 1'b1;
      ref_en   <= 1'b1;
    end else begin
      if (wr_en) begin
        mode_q <= csm_mode_e'(wr_mode);
        div_q  <= wr_div;
        keep_q <= wr_keep;
        trim_q <= wr_trim;
      end
      want_fll <= (mode_q == M_ENG);
      want_ref <= (mode_q == M_BYP) || (mode_q == M_LPBYP);
      // an enable is only dropped once its gate is seen shut
      fll_en   <= (mode_q == M_ENG) || (mode_q == M_BYP) || fll_seen;
      ref_en   <= (mode_q != M_STOP) || keep_q || ref_seen;
    end
  end
endmodule

// File: rtl/csm_gate.sv
module csm_gate #(
  parameter int SYNC_N = 2
) (
  input  logic src_clk,
  input  logic rst,
  input  logic req,
  output logic gate_on
);
  logic [SYNC_N-1:0] sh;

  always_ff @(posedge src_clk or posedge rst) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_N-2:0], req};
  end

  // opened/closed on the falling edge so the gated clock never gets a partial high phase
  always_ff @(negedge src_clk or posedge rst) begin
    if (rst) gate_on <= 1'b0;
    else     gate_on <= sh[SYNC_N-1];
  end
endmodule

// File: rtl/csm_div.sv
module csm_div #(
  parameter int DIV_W = 2,
  parameter int SYNC_N = 2
) (
  input  logic             mclk,
  input  logic             rst,
  input  logic [DIV_W-1:0] sel,
  output logic             pen
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [DIV_W-1:0] sel_s [SYNC_N];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  function automatic logic [CNT_W-1:0] lim_of(input logic [DIV_W-1:0] s);
    logic [CNT_W-1:0] f;
    for (int i = 0; i < CNT_W; i++) f[i] = (i < int'(s));
    return f;
  endfunction

  always_ff @(posedge mclk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < SYNC_N; i++) sel_s[i] <= '0;
      cnt <= '0;
      lim <= '0;
    end else begin
      sel_s[0] <= sel;
      for (int i = 1; i < SYNC_N; i++) sel_s[i] <= sel_s[i-1];
      if (cnt == lim) begin
        cnt <= '0;
        lim <= lim_of(sel_s[SYNC_N-1]);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(negedge mclk or posedge rst) begin
    if (rst) pen <= 1'b0;
    else     pen <= (cnt == lim);
  end
endmodule

// File: rtl/clksrc_mode_ctrl.sv
module clksrc_mode_ctrl
  import csm_pkg::*;
#(
  parameter int TRIM_W = 9,
  parameter int DIV_W = 2,
  parameter int SYNC_N = 2,
  parameter logic [TRIM_W-1:0] TRIM_RST = 9'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_keep_ref,
  input  logic [TRIM_W-1:0] cfg_trim,
  input  logic              ref_clk,
  input  logic              loop_clk,
  input  logic              loop_lock,
  output logic              loop_en,
  output logic              ref_en,
  output logic [TRIM_W-1:0] ref_trim,
  output logic              clk_out
);
  localparam int NSRC = 2;

  csm_mode_e        mode_q;
  logic [DIV_W-1:0] div_q;
  logic             keep_q;
  logic             want_ref, want_fll;
  logic             ref_seen, fll_seen;
  logic [NSRC-1:0]  src_v, req_v, gate_v;
  logic             ref_gate, fll_gate;
  logic [SYNC_N-1:0] ref_bk, fll_bk;
  logic             mux_clk, pen;

  csm_cfg #(.TRIM_W(TRIM_W), .DIV_W(DIV_W), .TRIM_RST(TRIM_RST)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_mode(cfg_mode), .wr_div(cfg_div),
    .wr_keep(cfg_keep_ref), .wr_trim(cfg_trim), .ref_seen(ref_seen), .fll_seen(fll_seen),
    .mode_q(mode_q), .div_q(div_q), .keep_q(keep_q), .trim_q(ref_trim),
    .want_ref(want_ref), .want_fll(want_fll), .fll_en(loop_en), .ref_en(ref_en)
  );

  assign src_v    = {loop_clk, ref_clk};
  assign req_v[0] = want_ref & ~gate_v[1];
  assign req_v[1] = want_fll & loop_lock & ~gate_v[0];

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    csm_gate #(.SYNC_N(SYNC_N)) u_gate (
      .src_clk(src_v[g]), .rst(rst), .req(req_v[g]), .gate_on(gate_v[g])
    );
  end

  assign ref_gate = gate_v[0];
  assign fll_gate = gate_v[1];
  assign mux_clk  = |(src_v & gate_v);

  // gate status back into the register domain
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_bk <= '0;
      fll_bk <= '0;
    end else begin
      ref_bk <= {ref_bk[SYNC_N-2:0], ref_gate};
      fll_bk <= {fll_bk[SYNC_N-2:0], fll_gate};
    end
  end
  assign ref_seen = ref_bk[SYNC_N-1];
  assign fll_seen = fll_bk[SYNC_N-1];

  csm_div #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_div (
    .mclk(mux_clk), .rst(rst), .sel(div_q), .pen(pen)
  );

  assign clk_out = mux_clk & pen;
endmodule

// File: rtl/csm_chk.sv
module csm_chk
  import csm_pkg::*;
#(
  parameter int TRIM_W = 9,
  parameter logic [TRIM_W-1:0] TRIM_RST = 9'h100
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [TRIM_W-1:0] cfg_trim,
  input logic [TRIM_W-1:0] ref_trim,
  input logic              loop_en,
  input logic              ref_en,
  input logic              ref_gate,
  input logic              fll_gate,
  input logic              ref_seen,
  input logic              fll_seen,
  input logic              keep_q,
  input csm_mode_e         mode_q
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (loop_en && ref_en && ref_trim == TRIM_RST));

  // R7
  a_r7_one_gate: assert property (@(posedge clk) disable iff (rst)
    !(ref_gate && fll_gate));

  a_r7_loop_gate_enabled: assert property (@(posedge clk) disable iff (rst)
    fll_gate |-> loop_en);

  a_r7_ref_gate_enabled: assert property (@(posedge clk) disable iff (rst)
    ref_gate |-> ref_en);

  // R4
  a_r4_loop_off: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q) == M_LPBYP && !$past(fll_seen)) |-> !loop_en);

  // R5
  a_r5_stop_enables: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q) == M_STOP && !$past(keep_q) && !$past(ref_seen) && !$past(fll_seen))
      |-> (!ref_en && !loop_en));

  // R10
  a_r10_trim_load: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (ref_trim == $past(cfg_trim)));

  a_r10_trim_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(ref_trim));
endmodule

bind clksrc_mode_ctrl csm_chk #(.TRIM_W(TRIM_W), .TRIM_RST(TRIM_RST)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_trim(cfg_trim), .ref_trim(ref_trim),
  .loop_en(loop_en), .ref_en(ref_en), .ref_gate(ref_gate), .fll_gate(fll_gate),
  .ref_seen(ref_seen), .fll_seen(fll_seen), .keep_q(keep_q), .mode_q(mode_q)
);

// File: tb/test_clksrc_mode_ctrl.sv
`timescale 1ns/1ps
module test_clksrc_mode_ctrl;
  logic clk = 0, rst = 1;
  logic ref_clk = 0, loop_clk = 0, loop_lock = 1;
  logic cfg_we = 0, cfg_keep_ref = 0;
  logic [1:0] cfg_mode = 0, cfg_div = 0;
  logic [8:0] cfg_trim = 9'h100;
  logic loop_en, ref_en, clk_out;
  logic [8:0] ref_trim;

  always #2  clk = ~clk;       // 250 MHz
  always #20 ref_clk = ~ref_clk;
  always #5  loop_clk = ~loop_clk;

  clksrc_mode_ctrl i_clksrc_mode_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_div(cfg_div),
    .cfg_keep_ref(cfg_keep_ref), .cfg_trim(cfg_trim), .ref_clk(ref_clk),
    .loop_clk(loop_clk), .loop_lock(loop_lock), .loop_en(loop_en), .ref_en(ref_en),
    .ref_trim(ref_trim), .clk_out(clk_out)
  );

  int total = 0, bad = 0;
  int edges = 0, runts = 0;
  bit mon_on = 0, done = 0;
  realtime last_rise = -1.0;

  always @(posedge clk_out) begin
    edges++;
    if (mon_on && last_rise >= 0.0 && ($realtime - last_rise) < 9.5) runts++;
    last_rise = $realtime;
  end
  always @(negedge clk_out)
    if (mon_on && ($realtime - last_rise) < 4.5) runts++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] m, input logic [1:0] d, input logic k, input logic [8:0] t);
    @(negedge clk);
    cfg_mode = m; cfg_div = d; cfg_keep_ref = k; cfg_trim = t; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic count_win(output int n);
    edges = 0;
    #3200;
    n = edges;
  endtask

  function automatic bit near(input int a, input int e);
    return (e == 0) ? (a == 0) : (a >= e - 1 && a <= e + 1);
  endfunction

  // {mode, div, keep, lock, expected edges in 3200 ns, loop_en, ref_en}
  localparam int NV = 8;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 2'd0, 1'b0, 1'b1, 10'd320, 1'b1, 1'b1},  // R2 R6 loop /1
    {2'd0, 2'd1, 1'b0, 1'b1, 10'd160, 1'b1, 1'b1},  // R6 loop /2
    {2'd1, 2'd0, 1'b0, 1'b1, 10'd80,  1'b1, 1'b1},  // R3 ref /1
    {2'd1, 2'd2, 1'b0, 1'b1, 10'd20,  1'b1, 1'b1},  // R6 ref /4
    {2'd2, 2'd3, 1'b0, 1'b1, 10'd10,  1'b0, 1'b1},  // R4 ref /8
    {2'd3, 2'd0, 1'b1, 1'b1, 10'd0,   1'b0, 1'b1},  // R5 keep ref
    {2'd3, 2'd0, 1'b0, 1'b1, 10'd0,   1'b0, 1'b0},  // R5 ref off
    {2'd0, 2'd3, 1'b0, 1'b1, 10'd40,  1'b1, 1'b1}   // R8 R6 wake to loop /8
  };

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (20) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ref_trim == 9'h100, "R1 trim", ref_trim, 9'h100);
    chk(loop_en == 1'b1, "R1 loop_en", loop_en, 1);
    chk(ref_en == 1'b1, "R1 ref_en", ref_en, 1);
    #1000;
    mon_on = 1;
    count_win(n);
    chk(near(n, 320), "R1 default loop /1", n, 320);

    for (int i = 0; i < NV; i++) begin
      loop_lock = VEC[i][12];
      wr(VEC[i][17:16], VEC[i][15:14], VEC[i][13], cfg_trim);
      #1000;
      count_win(n);
      chk(near(n, int'(VEC[i][11:2])), "R2-6 vector edges", n, int'(VEC[i][11:2]));
      chk(loop_en == VEC[i][1], "R4 R5 vector loop_en", loop_en, VEC[i][1]);
      chk(ref_en == VEC[i][0], "R5 vector ref_en", ref_en, VEC[i][0]);
    end

    // R8: leave stop with lock low, output stays quiet until lock
    wr(2'd3, 2'd0, 1'b0, cfg_trim);
    #1000;
    loop_lock = 0;
    wr(2'd0, 2'd0, 1'b0, cfg_trim);
    #1000;
    count_win(n);
    chk(n == 0, "R8 no lock no clock", n, 0);
    chk(loop_en == 1'b1, "R8 loop_en while waiting", loop_en, 1);
    loop_lock = 1;
    #1000;
    count_win(n);
    chk(near(n, 320), "R8 lock releases loop", n, 320);

    // R10: trim load, then ignored fields
    wr(2'd0, 2'd0, 1'b0, 9'h0A5);
    @(negedge clk);
    chk(ref_trim == 9'h0A5, "R10 trim load", ref_trim, 9'h0A5);
    @(negedge clk);
    cfg_mode = 2'd3; cfg_div = 2'd3; cfg_trim = 9'h1FF;
    #1000;
    chk(ref_trim == 9'h0A5, "R10 trim ignored", ref_trim, 9'h0A5);
    count_win(n);
    chk(near(n, 320), "R10 mode and divider ignored", n, 320);

    // R9: divider change on the fly, then back
    wr(2'd0, 2'd2, 1'b0, 9'h0A5);
    #1000;
    count_win(n);
    chk(near(n, 80), "R9 loop /4 after change", n, 80);
    wr(2'd1, 2'd1, 1'b0, 9'h0A5);
    #1000;
    count_win(n);
    chk(near(n, 40), "R9 ref /2 after change", n, 40);

    chk(runts == 0, "R7 R9 no runt pulses", runts, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule